// File: doc/BRIEF.md
# Programmable-Threshold FIFO with Shared Enable/Load Pin

This block is a first-in first-out buffer of 9-bit words with a full flag, an empty flag, and two threshold flags: almost-empty and almost-full. One input pin has two jobs, and the block picks between them from the level on that pin while reset is held. In the dual-enable mode the pin is a second write enable, and a word is stored only when both enables agree. In the threshold mode the pin is a load strobe. Each strobed write cycle puts the input word into one of four offset registers, and the target register advances on each strobe. The offset registers set the level at which each threshold flag asserts.

In threshold mode the same pin also steers reads. A read request with the strobe low does not pop a word. It places the next offset register on the output bus, rotating through the registers in the same order used for loading. The output bus goes to high impedance whenever the output enable is high. Write side and read side share one clock. All flags come from registered state, so they are valid one edge after the request that moves them.

Top module: `fifo_pf_top`

## Requirements
- R1: The level on `wen2_ld` is captured while `rst_n` is low: high selects dual-enable mode and low selects threshold mode. In dual-enable mode, `ren_n` low with `wen2_ld` low is an ordinary read. In threshold mode the same inputs read back an offset register.
- R2: In dual-enable mode, a word is stored on a rising edge only when `wen1_n` is 0 and `wen2_ld` is 1. With any other combination nothing is stored.
- R3: When DEPTH words are held, `full_n` is 0 and write requests are ignored, so no stored word is overwritten.
- R4: A read accepted while the buffer is full sets `full_n` back to 1 on the following edge.
- R5: In threshold mode, `wen1_n`=0 with `wen2_ld`=0 loads the input word into offset registers, one per edge, without storing it in the buffer. The order is: empty-offset bits [7:0], empty-offset upper bits (din[AW-9:0]), full-offset bits [7:0], full-offset upper bits.
- R6: A fifth load returns to the empty-offset low byte, so the load pointer counts modulo 4.
- R7: After reset, both offset low bytes are 0x07 and both upper fields are 0.
- R8: With `oe_n`=1 all nine `dout` bits are high impedance. With `oe_n`=0, `dout` shows the output register.
- R9: In threshold mode, `ren_n`=0 with `wen2_ld`=0 copies the next offset register, zero-extended, into the output register. The order matches R5 and the pointer wraps after four. The buffer is not popped.
- R10: `alm_empty_n` is 0 while the word count is at or below the empty offset. `alm_full_n` is 0 while the free space (DEPTH minus count) is at or below the full offset.
- R11: Reset clears both buffer pointers and both offset pointers, clears the output register to 0, and restores the default offsets. Afterwards `empty_n`=0, `full_n`=1, `alm_empty_n`=0 and `alm_full_n`=1.
- R12: A read of an empty buffer is ignored, and the output register keeps its last value.
- R13: Words leave in the order they were stored. A read and a write in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the write side and the read side |
| rst_n | input | 1 | Synchronous reset, active low |
| wen1_n | input | 1 | Primary write enable, active low |
| wen2_ld | input | 1 | Second write enable or offset load strobe, chosen at reset |
| ren_n | input | 1 | Read enable, active low |
| oe_n | input | 1 | Output enable, active low |
| din | input | 9 | Write data / offset load data |
| dout | output | 9 | Output register, or high impedance |
| full_n | output | 1 | Low when the buffer is full |
| empty_n | output | 1 | Low when the buffer is empty |
| alm_empty_n | output | 1 | Low at or below the empty threshold |
| alm_full_n | output | 1 | Low at or below the full threshold of free space |

## Verification
The properties assume that controls are never unknown after reset. They also assume that every ordinary read in threshold mode is issued with `wen2_ld` held high. Only under that condition can the read-related properties tell a pop from an offset read-back. The bench therefore drives every pop with `wen2_ld` high, and uses `wen2_ld` low only for loads and read-backs. All inputs change one time unit after a rising edge, and outputs are sampled at the same point, so nothing depends on process order at the edge.

// File: rtl/fifo_pf_pkg.sv
package fifo_pf_pkg;

    // Role of the shared enable/load pin, captured while reset is held
    typedef enum logic {
        MODE_DUAL_WE   = 1'b0,
        MODE_PROG_FLAG = 1'b1
    } pin_mode_e;

    // Rotation order of the offset registers (load and read-back share it)
    typedef enum logic [1:0] {
        SLOT_E_LO = 2'd0,
        SLOT_E_HI = 2'd1,
        SLOT_F_LO = 2'd2,
        SLOT_F_HI = 2'd3
    } off_slot_e;

    localparam int unsigned OFF_LO_W   = 8;
    localparam logic [7:0]  OFF_LO_DEF = 8'h07;

endpackage

// File: rtl/fifo_pf_mem.sv
module fifo_pf_mem #(
    parameter int unsigned DW    = 9,
    parameter int unsigned DEPTH = 1024,
    parameter int unsigned AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store_q[waddr] <= wdata;
        end
    end

    // Read data is captured by the output register in the top module
    assign rdata = store_q[raddr];

endmodule

// File: rtl/fifo_pf_offsets.sv
module fifo_pf_offsets
    import fifo_pf_pkg::*;
#(
    parameter int unsigned DW = 9,
    parameter int unsigned AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [7:0]    load_data,
    input  logic          rb_step,
    output logic [AW-1:0] empty_off,
    output logic [AW-1:0] full_off,
    output logic [DW-1:0] rb_word
);

    localparam int unsigned HI_W = (AW > OFF_LO_W) ? AW - OFF_LO_W : 1;

    typedef struct packed {
        logic [1:0]          ld_ptr;
        logic [1:0]          rb_ptr;
        logic [7:0]          e_lo;
        logic [HI_W-1:0]     e_hi;
        logic [7:0]          f_lo;
        logic [HI_W-1:0]     f_hi;
    } off_regs_t;

    off_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!rst_n) begin
            r_d.ld_ptr = '0;
            r_d.rb_ptr = '0;
            r_d.e_lo   = OFF_LO_DEF;
            r_d.e_hi   = '0;
            r_d.f_lo   = OFF_LO_DEF;
            r_d.f_hi   = '0;
        end else begin
            if (load) begin
                unique case (off_slot_e'(r_q.ld_ptr))
                    SLOT_E_LO: r_d.e_lo = load_data;
                    SLOT_E_HI: r_d.e_hi = load_data[HI_W-1:0];
                    SLOT_F_LO: r_d.f_lo = load_data;
                    SLOT_F_HI: r_d.f_hi = load_data[HI_W-1:0];
                    default:   r_d.e_lo = load_data;
                endcase
                r_d.ld_ptr = r_q.ld_ptr + 2'd1;
            end
            if (rb_step) begin
                r_d.rb_ptr = r_q.rb_ptr + 2'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    // Threshold values: the parameter picks whether upper bits exist
    generate
        if (AW > OFF_LO_W) begin : g_wide
            assign empty_off = {r_q.e_hi, r_q.e_lo};
            assign full_off  = {r_q.f_hi, r_q.f_lo};
        end else begin : g_narrow
            assign empty_off = r_q.e_lo[AW-1:0];
            assign full_off  = r_q.f_lo[AW-1:0];
        end
    endgenerate

    always_comb begin
        unique case (off_slot_e'(r_q.rb_ptr))
            SLOT_E_LO: rb_word = DW'(r_q.e_lo);
            SLOT_E_HI: rb_word = DW'(r_q.e_hi);
            SLOT_F_LO: rb_word = DW'(r_q.f_lo);
            SLOT_F_HI: rb_word = DW'(r_q.f_hi);
            default:   rb_word = '0;
        endcase
    end

endmodule

// File: rtl/fifo_pf_flags.sv
module fifo_pf_flags #(
    parameter int unsigned DEPTH = 1024,
    parameter int unsigned AW    = $clog2(DEPTH),
    parameter int unsigned CW    = AW + 1
) (
    input  logic [CW-1:0] count,
    input  logic [AW-1:0] empty_off,
    input  logic [AW-1:0] full_off,
    output logic          is_full,
    output logic          is_empty,
    output logic          is_alm_empty,
    output logic          is_alm_full
);

    logic [CW-1:0] free_slots;

    always_comb begin
        free_slots   = CW'(DEPTH) - count;
        is_full      = (count == CW'(DEPTH));
        is_empty     = (count == '0);
        is_alm_empty = (count <= {1'b0, empty_off});
        is_alm_full  = (free_slots <= {1'b0, full_off});
    end

endmodule

// File: rtl/fifo_pf_top.sv
module fifo_pf_top
    import fifo_pf_pkg::*;
#(
    parameter int unsigned DW    = 9,
    parameter int unsigned DEPTH = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wen1_n,
    input  logic          wen2_ld,
    input  logic          ren_n,
    input  logic          oe_n,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          full_n,
    output logic          empty_n,
    output logic          alm_empty_n,
    output logic          alm_full_n
);

    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned CW = AW + 1;

    typedef struct packed {
        pin_mode_e       mode;
        logic [AW-1:0]   wptr;
        logic [AW-1:0]   rptr;
        logic [CW-1:0]   count;
        logic [DW-1:0]   oreg;
    } top_regs_t;

    top_regs_t s_d, s_q;

    logic          is_full, is_empty, is_alm_empty, is_alm_full;
    logic          wr_do, rd_do, ld_do, rb_do;
    logic [DW-1:0] mem_rdata, rb_word;
    logic [AW-1:0] empty_off, full_off;

    // Request decode: the captured mode only decides what wen2_ld low means
    always_comb begin
        logic prog;
        prog  = (s_q.mode == MODE_PROG_FLAG);
        wr_do = rst_n && !wen1_n && wen2_ld && !is_full;
        ld_do = rst_n && prog && !wen1_n && !wen2_ld;
        rb_do = rst_n && prog && !ren_n && !wen2_ld;
        rd_do = rst_n && !ren_n && !(prog && !wen2_ld) && !is_empty;
    end

    always_comb begin
        s_d = s_q;
        if (!rst_n) begin
            s_d.mode  = wen2_ld ? MODE_DUAL_WE : MODE_PROG_FLAG;
            s_d.wptr  = '0;
            s_d.rptr  = '0;
            s_d.count = '0;
            s_d.oreg  = '0;
        end else begin
            if (wr_do) begin
                s_d.wptr = s_q.wptr + AW'(1);
            end
            if (rd_do) begin
                s_d.rptr = s_q.rptr + AW'(1);
                s_d.oreg = mem_rdata;
            end else if (rb_do) begin
                s_d.oreg = rb_word;
            end
            s_d.count = s_q.count + CW'(wr_do) - CW'(rd_do);
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    fifo_pf_mem #(
        .DW    (DW),
        .DEPTH (DEPTH),
        .AW    (AW)
    ) i_mem (
        .clk   (clk),
        .we    (wr_do),
        .waddr (s_q.wptr),
        .wdata (din),
        .raddr (s_q.rptr),
        .rdata (mem_rdata)
    );

    fifo_pf_offsets #(
        .DW (DW),
        .AW (AW)
    ) i_offsets (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ld_do),
        .load_data (din[7:0]),
        .rb_step   (rb_do),
        .empty_off (empty_off),
        .full_off  (full_off),
        .rb_word   (rb_word)
    );

    fifo_pf_flags #(
        .DEPTH (DEPTH),
        .AW    (AW),
        .CW    (CW)
    ) i_flags (
        .count        (s_q.count),
        .empty_off    (empty_off),
        .full_off     (full_off),
        .is_full      (is_full),
        .is_empty     (is_empty),
        .is_alm_empty (is_alm_empty),
        .is_alm_full  (is_alm_full)
    );

    assign full_n      = ~is_full;
    assign empty_n     = ~is_empty;
    assign alm_empty_n = ~is_alm_empty;
    assign alm_full_n  = ~is_alm_full;
    assign dout        = oe_n ? {DW{1'bz}} : s_q.oreg;

endmodule

// File: rtl/fifo_pf_chk.sv
module fifo_pf_chk #(
    parameter int unsigned DW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wen1_n,
    input logic          wen2_ld,
    input logic          ren_n,
    input logic          oe_n,
    input logic [DW-1:0] dout,
    input logic          full_n,
    input logic          empty_n,
    input logic          alm_empty_n,
    input logic          alm_full_n
);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && ren_n) |=> !full_n);

    p_full_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && !ren_n && wen2_ld) |=> full_n);

    p_empty_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_n && wen1_n) |=> !empty_n);

    p_empty_read_keeps_out_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_n && wen2_ld && !oe_n) |=> (oe_n || $stable(dout)));

    p_flags_disjoint_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (full_n || empty_n));

    p_alm_empty_on_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !empty_n |-> !alm_empty_n);

    p_alm_full_on_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !full_n |-> !alm_full_n);

    p_reset_flags_r11: assert property (@(posedge clk)
        !rst_n |=> (!empty_n && full_n && !alm_empty_n && alm_full_n));

endmodule

bind fifo_pf_top fifo_pf_chk #(.DW(DW)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wen1_n      (wen1_n),
    .wen2_ld     (wen2_ld),
    .ren_n       (ren_n),
    .oe_n        (oe_n),
    .dout        (dout),
    .full_n      (full_n),
    .empty_n     (empty_n),
    .alm_empty_n (alm_empty_n),
    .alm_full_n  (alm_full_n)
);

// File: tb/test_fifo_pf_top.sv
`timescale 1ns/1ps
module test_fifo_pf_top;

    localparam int DW    = 9;
    localparam int DEPTH = 1024;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wen1_n = 1'b1;
    logic          wen2_ld = 1'b1;
    logic          ren_n = 1'b1;
    logic          oe_n = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          full_n, empty_n, alm_empty_n, alm_full_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    fifo_pf_top #(.DW(DW), .DEPTH(DEPTH)) i_fifo_pf_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .wen1_n      (wen1_n),
        .wen2_ld     (wen2_ld),
        .ren_n       (ren_n),
        .oe_n        (oe_n),
        .din         (din),
        .dout        (dout),
        .full_n      (full_n),
        .empty_n     (empty_n),
        .alm_empty_n (alm_empty_n),
        .alm_full_n  (alm_full_n)
    );

    // Row: {wen1_n, wen2_ld, ren_n, din[8:0], expected dout[8:0], expected empty_n}
    localparam logic [21:0] VEC [8] = '{
        {1'b0, 1'b1, 1'b1, 9'h101, 9'h000, 1'b1},
        {1'b0, 1'b0, 1'b1, 9'h0AA, 9'h000, 1'b1},
        {1'b1, 1'b1, 1'b1, 9'h055, 9'h000, 1'b1},
        {1'b0, 1'b1, 1'b1, 9'h1F0, 9'h000, 1'b1},
        {1'b1, 1'b1, 1'b0, 9'h000, 9'h101, 1'b1},
        {1'b0, 1'b1, 1'b0, 9'h033, 9'h1F0, 1'b1},
        {1'b1, 1'b1, 1'b0, 9'h000, 9'h033, 1'b0},
        {1'b1, 1'b1, 1'b0, 9'h000, 9'h033, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic pin);
        rst_n = 1'b0; wen2_ld = pin; wen1_n = 1'b1; ren_n = 1'b1;
        cycle();
        cycle();
        rst_n = 1'b1; wen2_ld = 1'b1;
    endtask

    task automatic wr(input logic [DW-1:0] d);
        wen1_n = 1'b0; wen2_ld = 1'b1; din = d;
        cycle();
        wen1_n = 1'b1;
    endtask

    task automatic rd();
        ren_n = 1'b0; wen2_ld = 1'b1;
        cycle();
        ren_n = 1'b1;
    endtask

    task automatic ld(input logic [DW-1:0] d);
        wen1_n = 1'b0; wen2_ld = 1'b0; din = d;
        cycle();
        wen1_n = 1'b1; wen2_ld = 1'b1;
    endtask

    task automatic rback();
        ren_n = 1'b0; wen2_ld = 1'b0;
        cycle();
        ren_n = 1'b1; wen2_ld = 1'b1;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int mism;
        logic [DW-1:0] expw;
        #1;
        // Dual-enable mode
        do_reset(1'b1);
        check("R11 empty_n", 32'(empty_n), 32'd0);
        check("R11 full_n", 32'(full_n), 32'd1);
        check("R11 alm_empty_n", 32'(alm_empty_n), 32'd0);
        check("R11 alm_full_n", 32'(alm_full_n), 32'd1);
        check("R11 dout", 32'(dout), 32'd0);

        // Vector table: R2 gating, R13 order and simultaneous access, R12 empty read
        for (int i = 0; i < 8; i++) begin
            wen1_n  = VEC[i][21];
            wen2_ld = VEC[i][20];
            ren_n   = VEC[i][19];
            din     = VEC[i][18:10];
            cycle();
            check($sformatf("R2/R13/R12 row%0d dout", i), 32'(dout), 32'(VEC[i][9:1]));
            check($sformatf("R2/R13/R12 row%0d empty_n", i), 32'(empty_n), 32'(VEC[i][0]));
        end
        wen1_n = 1'b1; wen2_ld = 1'b1; ren_n = 1'b1;

        // R1: in dual mode, ren low with wen2 low is a plain read (empty, ignored)
        wen1_n = 1'b0; wen2_ld = 1'b0; ren_n = 1'b0;
        cycle();
        wen1_n = 1'b1; wen2_ld = 1'b1; ren_n = 1'b1;
        check("R1 dual no readback dout", 32'(dout), 32'h033);
        check("R1 dual no write empty_n", 32'(empty_n), 32'd0);

        // Fill: default thresholds (R7, R10), full (R3), release (R4)
        for (int i = 0; i < DEPTH; i++) begin
            wr(DW'(i));
            if (i == 6) check("R7 R10 alm_empty_n at 7", 32'(alm_empty_n), 32'd0);
            if (i == 7) check("R7 R10 alm_empty_n at 8", 32'(alm_empty_n), 32'd1);
            if (i == DEPTH - 8) check("R7 R10 alm_full_n at 1017", 32'(alm_full_n), 32'd0);
            if (i == DEPTH - 9) check("R7 R10 alm_full_n at 1016", 32'(alm_full_n), 32'd1);
        end
        check("R3 full_n at depth", 32'(full_n), 32'd0);
        wr(9'h1AA);
        check("R3 full_n after blocked write", 32'(full_n), 32'd0);
        rd();
        check("R4 full_n after read", 32'(full_n), 32'd1);
        check("R3 first word intact", 32'(dout), 32'd0);
        wr(9'h0BB);
        check("R3 one slot free after read", 32'(full_n), 32'd0);
        mism = 0;
        for (int k = 1; k <= DEPTH; k++) begin
            rd();
            expw = (k == DEPTH) ? 9'h0BB : DW'(k);
            if (dout !== expw) mism++;
        end
        check("R13 R3 drain order mismatches", 32'(mism), 32'd0);
        check("R13 empty after drain", 32'(empty_n), 32'd0);

        // R8 output enable
        oe_n = 1'b1;
        #1;
        check("R8 hi-z", 32'(dout === 9'bz), 32'd1);
        oe_n = 1'b0;
        #1;
        check("R8 driven", 32'(dout), 32'h0BB);

        // Threshold mode
        do_reset(1'b0);
        check("R11 dout after reset", 32'(dout), 32'd0);
        rback(); check("R7 R9 slot0", 32'(dout), 32'h007);
        rback(); check("R7 R9 slot1", 32'(dout), 32'h000);
        rback(); check("R7 R9 slot2", 32'(dout), 32'h007);
        rback(); check("R7 R9 slot3", 32'(dout), 32'h000);
        check("R9 readback no pop", 32'(empty_n), 32'd0);

        ld(9'h012);
        check("R1 R5 load not stored", 32'(empty_n), 32'd0);
        ld(9'h001);
        ld(9'h020);
        ld(9'h002);
        ld(9'h003);
        check("R5 R6 loads not stored", 32'(empty_n), 32'd0);
        rback(); check("R6 wrapped slot0", 32'(dout), 32'h003);
        rback(); check("R5 slot1", 32'(dout), 32'h001);
        rback(); check("R5 slot2", 32'(dout), 32'h020);
        rback(); check("R5 slot3", 32'(dout), 32'h002);

        // empty offset 0x103 = 259, full offset 0x220 = 544 -> alm_full at count 480
        for (int i = 0; i < 480; i++) begin
            wr(DW'(i));
            if (i == 258) check("R10 alm_empty_n at 259", 32'(alm_empty_n), 32'd0);
            if (i == 259) check("R10 alm_empty_n at 260", 32'(alm_empty_n), 32'd1);
            if (i == 478) check("R10 alm_full_n at 479", 32'(alm_full_n), 32'd1);
            if (i == 479) check("R10 alm_full_n at 480", 32'(alm_full_n), 32'd0);
        end
        rd();
        check("R13 prog-mode pop first word", 32'(dout), 32'd0);

        // R11: reset restores defaults and flags
        do_reset(1'b0);
        check("R11 empty_n again", 32'(empty_n), 32'd0);
        check("R11 alm_full_n again", 32'(alm_full_n), 32'd1);
        rback();
        check("R11 default offset restored", 32'(dout), 32'h007);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule